// File: doc/BRIEF.md
# Serial Port Bit and Frame Timing Generator

This block produces the timing for a synchronous serial audio port. All of its
outputs are enables in the input clock domain. It divides the input clock down to a bit rate and
emits a one-cycle bit strobe at that rate. It then groups bits into words of a selectable length and
groups words into frames of a programmable size. From these it raises a word strobe, a frame strobe
and a frame sync level. The block creates no derived clock. A shift register elsewhere advances on
`bit_stb` and begins a word on `word_stb`.

The bit period in input cycles is a fixed divide-by-four, times a selectable factor of one or eight,
times an 8-bit modulus plus one. There are two framing modes. In normal mode only the first word slot
of each frame carries data. In network mode every slot carries a word. In each mode a frame of a single
word has its own meaning. The control inputs are copied into an active set only while the block is
disabled, or on the bit strobe that opens a frame. A change therefore never splits a frame.

Top module: `sfg_top`

## Requirements
- R1: While `en` is high, `bit_stb` is a one-cycle pulse that repeats every 4 × (8 if `psr_sel`=1, else 1) × (`pm_div`+1) input cycles. After `en` rises, the first pulse comes on the cycle at which that many cycles less one rising edges have passed.
- R2: `wl_code` sets the bits per word: 0 gives 8, 1 gives 10, 2 gives 12 and 3 gives 16. Word slots open on every such number of bit strobes, counted from the first strobe.
- R3: `frame_stb` coincides with the bit strobe that opens slot 0. It repeats every (`dc_div`+1) × word-length bit strobes.
- R4: With `net_mode`=1, `word_stb` marks the opening of every slot. With `net_mode`=0, it marks only the opening of slot 0, so one data word is sent per frame.
- R5: `fsync` rises on the cycle after `frame_stb`. With `fs_word`=1 it stays high for one word length of bit periods. With `fs_word`=0 it stays high for one bit period.
- R6: With `net_mode`=0 and `dc_div`=0, every word is a frame, and `fsync` lasts one bit period whatever the value of `fs_word`.
- R7: With `net_mode`=1 and `dc_div`=0, the block runs on demand. A word opens, with its frame strobe and sync, only when `word_req` is high on the bit strobe at a word boundary. Otherwise bit strobes continue while `word_stb`, `frame_stb` and `fsync` stay low.
- R8: A change to `psr_sel`, `pm_div`, `wl_code`, `dc_div`, `net_mode` or `fs_word` while enabled does not alter the frame under way. It takes effect from the next frame-opening bit strobe.
- R9: With `en` low, `bit_stb`, `word_stb` and `frame_stb` are low at once, and `fsync` is low after the next rising edge. Re-enabling restarts the count from zero.
- R10: While `rst_n` is low, every output is low.
- R11: An input clock of 19.2 MHz with a modulus value of 74, 8-bit words and `dc_div`=1 gives 64 kHz bits and 4 kHz frames. An input clock of 12 MHz with a modulus value of 1, 16-bit words and `dc_div`=1 gives 1.5 MHz bits and 46.875 kHz frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds every counter at zero |
| psr_sel | input | 1 | 1 adds the divide-by-eight stage |
| pm_div | input | 8 | Modulus divider value; the ratio is value+1 |
| wl_code | input | 2 | Word length code (8/10/12/16 bits) |
| dc_div | input | 5 | Words per frame minus one |
| net_mode | input | 1 | 1 selects network mode, 0 selects normal mode |
| fs_word | input | 1 | 1 makes the sync one word long |
| word_req | input | 1 | Demand for a word in on-demand operation |
| bit_stb | output | 1 | One-cycle bit rate enable |
| word_stb | output | 1 | Opening of a data word |
| frame_stb | output | 1 | Opening of a frame |
| fsync | output | 1 | Frame sync level |

## Verification
The hardest case to reach from the ports is a control change that lands in the middle of a frame. The
old timing has to survive up to the exact bit strobe that opens the next frame, and the new timing has
to take over from there. The bench changes every field at once, part of the way into a frame. It then
checks each cycle against a model of the old settings until that model predicts a frame opening. From
there it checks against a model of the new settings, re-based so that the opening counts as the new
frame's first bit. On-demand operation is driven with the request held low and then held high. The
extreme modulus and frame sizes are run as directed cases beside the seeded random settings.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

   typedef enum logic [1:0] {
      WLEN_8  = 2'b00,
      WLEN_10 = 2'b01,
      WLEN_12 = 2'b10,
      WLEN_16 = 2'b11
   } wlen_e;

   localparam int WLEN_MAX = 16;
   localparam int WBIT_W   = $clog2(WLEN_MAX + 1);

   function automatic logic [WBIT_W-1:0] wlen_bits(input wlen_e code);
      case (code)
         WLEN_8:  return WBIT_W'(8);
         WLEN_10: return WBIT_W'(10);
         WLEN_12: return WBIT_W'(12);
         default: return WBIT_W'(16);
      endcase
   endfunction

endpackage

// File: rtl/sfg_prescale.sv
module sfg_prescale #(
   parameter int FIXED_DIV = 4,
   parameter int SLOW_DIV  = 8,
   parameter int PM_W      = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            slow_sel,
   input  logic [PM_W-1:0] modulus,
   output logic            tick
);
   localparam int FW = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;
   localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

   if (FIXED_DIV < 1 || SLOW_DIV < 1 || PM_W < 1 || PM_W > 16) begin : g_bad_param
      $error("sfg_prescale: divider parameters out of range");
   end

   logic            tick_f;
   logic            tick_s;
   logic [PM_W-1:0] m_cnt;

   // fixed first stage
   if (FIXED_DIV > 1) begin : g_fixed
      localparam logic [FW-1:0] F_LAST = FW'(FIXED_DIV - 1);
      logic [FW-1:0] f_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              f_cnt <= '0;
         else if (!run)           f_cnt <= '0;
         else if (f_cnt == F_LAST) f_cnt <= '0;
         else                     f_cnt <= f_cnt + 1'b1;
      end
      assign tick_f = run & (f_cnt == F_LAST);

      // R1: a divided strobe is never two cycles wide
      p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end else begin : g_no_fixed
      assign tick_f = run;
   end

   // selectable second stage
   if (SLOW_DIV > 1) begin : g_slow
      localparam logic [SW-1:0] S_LAST = SW'(SLOW_DIV - 1);
      logic [SW-1:0] s_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 s_cnt <= '0;
         else if (!run || !slow_sel) s_cnt <= '0;
         else if (tick_f)            s_cnt <= (s_cnt == S_LAST) ? '0 : s_cnt + 1'b1;
      end
      assign tick_s = tick_f & (!slow_sel | (s_cnt == S_LAST));
   end else begin : g_no_slow
      assign tick_s = tick_f;
   end

   // programmable modulus stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      m_cnt <= '0;
      else if (!run)   m_cnt <= '0;
      else if (tick_s) m_cnt <= (m_cnt >= modulus) ? '0 : m_cnt + 1'b1;
   end

   assign tick = tick_s & (m_cnt >= modulus);

   // R9: no strobe while stopped
   p_run_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);

endmodule

// File: rtl/sfg_slot_ctr.sv
module sfg_slot_ctr #(
   parameter int BIT_W = 5,
   parameter int DC_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             bit_stb,
   input  logic [BIT_W-1:0] word_bits,
   input  logic [DC_W-1:0]  last_slot,
   input  logic             hold,
   output logic             word_edge,
   output logic             frame_edge,
   output logic             word_begin,
   output logic             slot_zero
);
   if (BIT_W < 2 || DC_W < 1) begin : g_bad_param
      $error("sfg_slot_ctr: counter widths out of range");
   end

   logic [BIT_W-1:0] idx;
   logic [DC_W-1:0]  slot;

   assign word_edge  = bit_stb & (idx == '0);
   assign slot_zero  = (slot == '0);
   assign frame_edge = word_edge & slot_zero;
   assign word_begin = word_edge & !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         slot <= '0;
      end else if (!run) begin
         idx  <= '0;
         slot <= '0;
      end else if (bit_stb && !(word_edge && hold)) begin
         if (idx >= word_bits - 1'b1) begin
            idx  <= '0;
            slot <= (slot >= last_slot) ? '0 : slot + 1'b1;
         end else begin
            idx  <= idx + 1'b1;
         end
      end
   end

   // R2: bit index stays inside the active word
   p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (idx < word_bits));

   // R7: an idle demand slot keeps the word unopened
   p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && hold && word_edge) |=> (idx == '0));

endmodule

// File: rtl/sfg_fsync.sv
module sfg_fsync (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic bit_stb,
   input  logic word_edge,
   input  logic frame_begin,
   input  logic long_sync,
   output logic fsync
);
   logic fs_q;
   logic long_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q   <= 1'b0;
         long_q <= 1'b0;
      end else if (!run) begin
         fs_q   <= 1'b0;
         long_q <= 1'b0;
      end else if (frame_begin) begin
         fs_q   <= 1'b1;
         long_q <= long_sync;
      end else if (bit_stb && (!long_q || word_edge)) begin
         fs_q   <= 1'b0;
      end
   end

   assign fsync = fs_q;

   // R5: sync only rises after a frame opening
   p_fs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync) |-> $past(frame_begin));

   // R9: stopping clears the sync on the next edge
   p_fs_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !fsync);

endmodule

// File: rtl/sfg_top.sv
module sfg_top #(
   parameter int FIXED_DIV = 4,
   parameter int SLOW_DIV  = 8,
   parameter int PM_W      = 8,
   parameter int DC_W      = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            psr_sel,
   input  logic [PM_W-1:0] pm_div,
   input  logic [1:0]      wl_code,
   input  logic [DC_W-1:0] dc_div,
   input  logic            net_mode,
   input  logic            fs_word,
   input  logic            word_req,
   output logic            bit_stb,
   output logic            word_stb,
   output logic            frame_stb,
   output logic            fsync
);
   import sfg_pkg::*;

   localparam int BIT_W = WBIT_W;

   if (DC_W < 1 || DC_W > 8) begin : g_bad_param
      $error("sfg_top: frame divider width out of range");
   end

   // active configuration
   logic            a_psr;
   logic [PM_W-1:0] a_pm;
   wlen_e           a_wl;
   logic [DC_W-1:0] a_dc;
   logic            a_net;
   logic            a_fsw;

   // configuration seen by framing logic (new set on a frame opening)
   wlen_e           u_wl;
   logic [DC_W-1:0] u_dc;
   logic            u_net;
   logic            u_fsw;
   logic            u_ondemand;
   logic            u_long;

   logic tick;
   logic word_edge;
   logic frame_edge;
   logic word_begin;
   logic slot_zero;
   logic frame_begin;
   logic load;

   assign load = !en | frame_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_psr <= 1'b0;
         a_pm  <= '0;
         a_wl  <= WLEN_8;
         a_dc  <= '0;
         a_net <= 1'b0;
         a_fsw <= 1'b0;
      end else if (load) begin
         a_psr <= psr_sel;
         a_pm  <= pm_div;
         a_wl  <= wlen_e'(wl_code);
         a_dc  <= dc_div;
         a_net <= net_mode;
         a_fsw <= fs_word;
      end
   end

   always_comb begin
      if (frame_edge) begin
         u_wl  = wlen_e'(wl_code);
         u_dc  = dc_div;
         u_net = net_mode;
         u_fsw = fs_word;
      end else begin
         u_wl  = a_wl;
         u_dc  = a_dc;
         u_net = a_net;
         u_fsw = a_fsw;
      end
      u_ondemand = u_net & (u_dc == '0);
      u_long     = u_fsw & !(!u_net & (u_dc == '0));
   end

   sfg_prescale #(
      .FIXED_DIV (FIXED_DIV),
      .SLOW_DIV  (SLOW_DIV),
      .PM_W      (PM_W)
   ) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (en),
      .slow_sel (a_psr),
      .modulus  (a_pm),
      .tick     (tick)
   );

   sfg_slot_ctr #(
      .BIT_W (BIT_W),
      .DC_W  (DC_W)
   ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (en),
      .bit_stb    (tick),
      .word_bits  (wlen_bits(u_wl)),
      .last_slot  (u_dc),
      .hold       (u_ondemand & !word_req),
      .word_edge  (word_edge),
      .frame_edge (frame_edge),
      .word_begin (word_begin),
      .slot_zero  (slot_zero)
   );

   assign frame_begin = word_begin & slot_zero;

   sfg_fsync u_fs (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (en),
      .bit_stb     (tick),
      .word_edge   (word_edge),
      .frame_begin (frame_begin),
      .long_sync   (u_long),
      .fsync       (fsync)
   );

   assign bit_stb   = tick;
   assign frame_stb = frame_begin;
   assign word_stb  = word_begin & (u_net | slot_zero);

   // R3: a frame opening is always a bit strobe and a word opening
   p_frame_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |-> (bit_stb && word_stb));

   // R4: in normal mode a data word only opens with a frame
   p_word_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && !u_net) |-> frame_stb);

   // R9: strobes are quiet while disabled
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!bit_stb && !word_stb && !frame_stb));

   // R8: the active set only moves on a frame opening or while stopped
   p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !frame_edge) |=> ($stable(a_pm) && $stable(a_dc) && $stable(a_wl)
                               && $stable(a_psr) && $stable(a_net)));

endmodule

// File: tb/tb_sfg_top.sv
module tb_sfg_top;
   localparam int CLK_P = 10;

   typedef struct {
      bit psr;
      int pm;
      int wl;
      int dc;
      bit net;
      bit fsw;
      bit req;
   } cfg_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       psr_sel = 1'b0;
   logic [7:0] pm_div = '0;
   logic [1:0] wl_code = '0;
   logic [4:0] dc_div = '0;
   logic       net_mode = 1'b0;
   logic       fs_word = 1'b0;
   logic       word_req = 1'b0;
   logic       bit_stb, word_stb, frame_stb, fsync;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   sfg_top dut (
      .clk(clk), .rst_n(rst_n), .en(en), .psr_sel(psr_sel), .pm_div(pm_div),
      .wl_code(wl_code), .dc_div(dc_div), .net_mode(net_mode), .fs_word(fs_word),
      .word_req(word_req), .bit_stb(bit_stb), .word_stb(word_stb),
      .frame_stb(frame_stb), .fsync(fsync)
   );

   function automatic int per(cfg_t c);
      return 4 * (c.psr ? 8 : 1) * (c.pm + 1);
   endfunction

   function automatic int wbits(int code);
      case (code)
         0: return 8;
         1: return 10;
         2: return 12;
         default: return 16;
      endcase
   endfunction

   function automatic int fbits(cfg_t c);
      return wbits(c.wl) * (c.dc + 1);
   endfunction

   // expected outputs t cycles (rising edges) after the run origin
   function automatic void model(input cfg_t c, input int t,
                                 output bit eb, output bit ew, output bit ef, output bit es);
      int p, w, f, k, l;
      bit idle;
      p = per(c);
      w = wbits(c.wl);
      f = fbits(c);
      idle = c.net && (c.dc == 0) && !c.req;
      l = (c.fsw && !(!c.net && c.dc == 0)) ? w : 1;
      k = t / p;
      eb = (t % p) == p - 1;
      ef = eb && !idle && (k % f == 0);
      ew = eb && !idle && (k % w == 0) && (c.net || ((k / w) % (c.dc + 1) == 0));
      es = (t >= p) && !idle && ((((t - p) / p) % f) < l);
   endfunction

   task automatic chk(input string req, input string what, input bit act, input bit exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at %0t: actual %0b expected %0b", req, what, $time, act, exp);
      end
   endtask

   task automatic drive(input cfg_t c);
      psr_sel  = c.psr;
      pm_div   = 8'(c.pm);
      wl_code  = 2'(c.wl);
      dc_div   = 5'(c.dc);
      net_mode = c.net;
      fs_word  = c.fsw;
      word_req = c.req;
   endtask

   // run config a; if tchg >= 0, switch inputs to b at cycle tchg
   task automatic run(input cfg_t a, input cfg_t b, input int n, input int tchg,
                      input string tag);
      bit use_b = 0;
      int ob = 0;
      bit eb, ew, ef, es;
      @(negedge clk);
      en = 1'b0;
      drive(a);
      @(negedge clk);
      en = 1'b1;
      for (int t = 0; t < n; t++) begin
         if (tchg >= 0 && t == tchg) drive(b);
         #1;
         if (use_b) model(b, t - ob, eb, ew, ef, es);
         else       model(a, t, eb, ew, ef, es);
         chk({tag, " R1"}, "bit_stb", bit_stb, eb);
         chk({tag, " R4"}, "word_stb", word_stb, ew);
         chk({tag, " R3"}, "frame_stb", frame_stb, ef);
         chk({tag, " R5"}, "fsync", fsync, es);
         if (!use_b && tchg >= 0 && t > tchg && ef) begin
            use_b = 1;
            ob = t - (per(b) - 1);
         end
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_P * 190000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      cfg_t c, d;
      void'($urandom(32'd20240611));

      // R10: outputs quiet in reset, even with the enable high
      en = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10", "bit_stb", bit_stb, 1'b0);
      chk("R10", "word_stb", word_stb, 1'b0);
      chk("R10", "frame_stb", frame_stb, 1'b0);
      chk("R10", "fsync", fsync, 1'b0);
      en = 1'b0;
      rst_n = 1'b1;

      // R11: first worked rate, 300-cycle bit, 4800-cycle frame
      c = '{psr:0, pm:74, wl:0, dc:1, net:0, fsw:0, req:0};
      run(c, c, 9700, -1, "R11a");
      // R11: second worked rate, 8-cycle bit, 256-cycle frame
      c = '{psr:0, pm:1, wl:3, dc:1, net:1, fsw:1, req:0};
      run(c, c, 600, -1, "R11b");
      // R1 R2: slow stage, 10-bit words, 3 slots, long sync
      c = '{psr:1, pm:0, wl:1, dc:2, net:1, fsw:1, req:0};
      run(c, c, 2100, -1, "R2");
      // R1: largest modulus with the slow stage (8192-cycle bit)
      c = '{psr:1, pm:255, wl:0, dc:0, net:0, fsw:0, req:0};
      run(c, c, 20000, -1, "R1max");
      // R3: 32 slots per frame, 12-bit words
      c = '{psr:0, pm:0, wl:2, dc:31, net:1, fsw:0, req:0};
      run(c, c, 3200, -1, "R3max");
      // R6: normal mode, single-word frames, word sync requested but forced short
      c = '{psr:0, pm:2, wl:2, dc:0, net:0, fsw:1, req:0};
      run(c, c, 1200, -1, "R6");
      // R7: on-demand, no request: bit strobes only
      c = '{psr:0, pm:1, wl:0, dc:0, net:1, fsw:1, req:0};
      run(c, c, 600, -1, "R7idle");
      // R7: on-demand with request held: back-to-back words
      c.req = 1;
      run(c, c, 600, -1, "R7req");
      // R8: change every field part-way through a frame
      c = '{psr:0, pm:2, wl:0, dc:3, net:1, fsw:0, req:0};
      d = '{psr:1, pm:0, wl:2, dc:1, net:0, fsw:1, req:0};
      run(c, d, 2500, 500, "R8");

      // R9: drop the enable while the sync is high
      c = '{psr:0, pm:0, wl:3, dc:0, net:1, fsw:1, req:1};
      run(c, c, 100, -1, "R9run");
      chk("R9", "fsync before stop", fsync, 1'b1);
      en = 1'b0;
      #1;
      chk("R9", "bit_stb", bit_stb, 1'b0);
      chk("R9", "word_stb", word_stb, 1'b0);
      chk("R9", "frame_stb", frame_stb, 1'b0);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         #1;
         chk("R9", "fsync", fsync, 1'b0);
         chk("R9", "bit_stb", bit_stb, 1'b0);
      end

      // seeded random settings
      for (int r = 0; r < 10; r++) begin
         int n;
         c.psr = ($urandom % 4) == 0;
         c.pm  = c.psr ? int'($urandom % 2) : int'($urandom % 6);
         c.wl  = int'($urandom % 4);
         c.dc  = int'($urandom % 6);
         c.net = $urandom % 2;
         c.fsw = $urandom % 2;
         c.req = $urandom % 2;
         n = 2 * fbits(c) * per(c) + per(c);
         if (n > 4000) n = 4000;
         run(c, c, n, -1, "RND");
      end

      en = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule